// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of 32 general-purpose pins. It sits behind a plain word-wide register bus with an address, a write strobe, write data and combinational read data. Each pin has an output data bit and an output enable bit. Its input is sampled through a two-flop synchronizer, and the synchronized value can be read back over the bus.

Every pin can raise an interrupt. Three per-pin control words choose how it senses: a level/edge select, a both-edges select, and a polarity. Detected events set sticky bits in a raw status word. A mask word gates the raw status into a masked status word. A write-one-to-clear word drops individual status bits. One registered interrupt line reports when any masked status bit is set.

The bank also holds pad settings for each pin: a pull enable, a pull direction, and a 3-bit drive-strength code. The code is kept as three bit-plane words and is presented on the pad outputs. The code value is (mA / 2) - 1, which spans 2 mA to 16 mA in steps of 2 mA.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every register reads zero. pin_out, pin_oe, both pull outputs, pad_drive and irq_out are all low, so every pin is an input, every interrupt is masked, pulls are off and the drive code is 0 (2 mA).
- R2: The word at 0x04 drives pin_out and the word at 0x08 drives pin_oe, with pin n on bit n. Both words read back what was written.
- R3: Reading 0x00 returns the pin inputs after a two-flop synchronizer. A change on pin_in is visible there two rising edges later.
- R4: Sense encoding per pin n, using bit n of each word. In 0x0C, 1 selects level sensing and 0 selects edge sensing. In 0x14, 1 means rising edge or high level and 0 means falling edge or low level. In 0x10, a 1 makes both edges count in edge mode, and the polarity bit is then ignored. The 0x10 bit has no effect in level mode.
- R5: The raw status word at 0x1C latches events. An edge detected on the synchronized input sets the pin's bit on the third rising edge after pin_in changes. A level-sensed pin sets its bit on every clock while its level is active. A set bit stays set until it is cleared.
- R6: A 1 in the mask word at 0x18 enables a pin and a 0 blocks it. The word at 0x20 reads raw status AND mask.
- R7: Writing 1 to bit n at 0x24 clears raw status bit n, and writing 0 changes nothing. 0x24 reads as zero. When a clear and a new event hit the same pin in the same cycle, the bit ends up set.
- R8: irq_out is the OR of all masked status bits, registered once, so it follows the status word by one clock.
- R9: 0x38 holds pull enables and 0x34 holds pull directions. pad_pull_up equals enable AND direction, and pad_pull_dn equals enable AND NOT direction.
- R10: The drive code of pin n has bit 0 at 0x58, bit 1 at 0x5C and bit 2 at 0x60, each on bit n. pad_drive[3n+2:3n] carries that code.
- R11: Writes to 0x00, 0x1C, 0x20 or any unmapped address change no register. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| pad_pull_up | output | 32 | Pull-up request per pin |
| pad_pull_dn | output | 32 | Pull-down request per pin |
| pad_drive | output | 96 | Drive code, 3 bits per pin |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The assertions rely on two conditions. First, bus_we is a single-cycle strobe whose address is stable for the whole cycle. Second, pin_in holds each value for at least several clocks, which matches how real pins are sampled. The stimulus changes pins and bus signals only on falling edges and holds each input vector for five clocks before it reads the status. Every clear write is one cycle long. Because of this, the stickiness, the masked-read and the one-clock interrupt lag all hold on every cycle the bench produces.

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pad_pull_up,
  output logic [NPIN-1:0]   pad_pull_dn,
  output logic [3*NPIN-1:0] pad_drive,
  output logic              irq_out
);
  localparam logic [AW-1:0] A_DIN  = AW'(8'h00);
  localparam logic [AW-1:0] A_DOUT = AW'(8'h04);
  localparam logic [AW-1:0] A_OE   = AW'(8'h08);
  localparam logic [AW-1:0] A_LVL  = AW'(8'h0C);
  localparam logic [AW-1:0] A_DUAL = AW'(8'h10);
  localparam logic [AW-1:0] A_POL  = AW'(8'h14);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h18);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h1C);
  localparam logic [AW-1:0] A_MST  = AW'(8'h20);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h24);
  localparam logic [AW-1:0] A_PSEL = AW'(8'h34);
  localparam logic [AW-1:0] A_PEN  = AW'(8'h38);
  localparam logic [AW-1:0] A_DRV0 = AW'(8'h58);
  localparam logic [AW-1:0] A_DRV1 = AW'(8'h5C);
  localparam logic [AW-1:0] A_DRV2 = AW'(8'h60);
  localparam int DRV_BITS = 3;

  logic [NPIN-1:0] dout_q, oe_q, lvl_q, dual_q, pol_q, mask_q, raw_q, psel_q, pen_q;
  logic [NPIN-1:0] s1_q, s2_q, prev_q;
  logic [DRV_BITS-1:0][NPIN-1:0] drv_q;
  logic            irq_q;

  logic [NPIN-1:0] rise, fall, edge_ev, lvl_ev, clr;

  assign rise    = s2_q & ~prev_q;
  assign fall    = ~s2_q & prev_q;
  assign edge_ev = ~lvl_q & ((dual_q & (rise | fall)) |
                             (~dual_q & pol_q & rise) |
                             (~dual_q & ~pol_q & fall));
  assign lvl_ev  = lvl_q & ~(s2_q ^ pol_q);
  assign clr     = (bus_we && bus_addr == A_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= '0; oe_q <= '0; lvl_q <= '0; dual_q <= '0; pol_q <= '0;
      mask_q <= '0; raw_q <= '0; psel_q <= '0; pen_q <= '0; drv_q <= '0;
      s1_q <= '0; s2_q <= '0; prev_q <= '0; irq_q <= 1'b0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      raw_q  <= (raw_q & ~clr) | edge_ev | lvl_ev;
      irq_q  <= |(raw_q & mask_q);
      if (bus_we) begin
        case (bus_addr)
          A_DOUT: dout_q   <= bus_wdata;
          A_OE:   oe_q     <= bus_wdata;
          A_LVL:  lvl_q    <= bus_wdata;
          A_DUAL: dual_q   <= bus_wdata;
          A_POL:  pol_q    <= bus_wdata;
          A_MSK:  mask_q   <= bus_wdata;
          A_PSEL: psel_q   <= bus_wdata;
          A_PEN:  pen_q    <= bus_wdata;
          A_DRV0: drv_q[0] <= bus_wdata;
          A_DRV1: drv_q[1] <= bus_wdata;
          A_DRV2: drv_q[2] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIN:  bus_rdata = s2_q;
      A_DOUT: bus_rdata = dout_q;
      A_OE:   bus_rdata = oe_q;
      A_LVL:  bus_rdata = lvl_q;
      A_DUAL: bus_rdata = dual_q;
      A_POL:  bus_rdata = pol_q;
      A_MSK:  bus_rdata = mask_q;
      A_RAW:  bus_rdata = raw_q;
      A_MST:  bus_rdata = raw_q & mask_q;
      A_PSEL: bus_rdata = psel_q;
      A_PEN:  bus_rdata = pen_q;
      A_DRV0: bus_rdata = drv_q[0];
      A_DRV1: bus_rdata = drv_q[1];
      A_DRV2: bus_rdata = drv_q[2];
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out     = dout_q;
  assign pin_oe      = oe_q;
  assign pad_pull_up = pen_q & psel_q;
  assign pad_pull_dn = pen_q & ~psel_q;
  assign irq_out     = irq_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_drv
    for (genvar b = 0; b < DRV_BITS; b++) begin : g_bit
      assign pad_drive[DRV_BITS*i + b] = drv_q[b][i];
    end
  end
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NPIN-1:0] bus_rdata,
  input logic [NPIN-1:0] raw_q,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] dout_q,
  input logic [NPIN-1:0] oe_q,
  input logic [NPIN-1:0] pad_pull_up,
  input logic [NPIN-1:0] pad_pull_dn,
  input logic            irq_out
);
  localparam logic [AW-1:0] A_DIN = AW'(8'h00);
  localparam logic [AW-1:0] A_RAW = AW'(8'h1C);
  localparam logic [AW-1:0] A_MST = AW'(8'h20);
  localparam logic [AW-1:0] A_CLR = AW'(8'h24);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_CLR) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  p_masked_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MST) |-> (bus_rdata == (raw_q & mask_q)));

  p_clear_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CLR) |-> (bus_rdata == '0));

  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == |($past(raw_q & mask_q))));

  p_pull_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_up & pad_pull_dn) == '0);

  p_readonly_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_DIN || bus_addr == A_RAW || bus_addr == A_MST))
    |=> ($stable(dout_q) && $stable(oe_q) && $stable(mask_q)));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .raw_q(raw_q), .mask_q(mask_q), .dout_q(dout_q),
  .oe_q(oe_q), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
  .irq_out(irq_out)
);

// File: tb/sim_gpio_bank_irq.sv
`timescale 1ns/1ps
module sim_gpio_bank_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pad_pull_up, pad_pull_dn;
  logic [95:0] pad_drive;
  logic        irq_out;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  gpio_bank_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pad_pull_up(pad_pull_up),
    .pad_pull_dn(pad_pull_dn), .pad_drive(pad_drive), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  logic [31:0] c_lvl, c_dual, c_pol;

  function automatic logic [31:0] lvl_act(input logic [31:0] v);
    return c_lvl & ~(v ^ c_pol);
  endfunction

  function automatic logic [31:0] edge_hit(input logic [31:0] o, input logic [31:0] n);
    logic [31:0] up, dn;
    up = ~o & n;
    dn = o & ~n;
    return ~c_lvl & ((c_dual & (up | dn)) | (~c_dual & c_pol & up) | (~c_dual & ~c_pol & dn));
  endfunction

  task automatic run_sweep(input logic [31:0] ty, input logic [31:0] du,
                           input logic [31:0] po, input logic [31:0] mk,
                           input logic [31:0] seed);
    logic [31:0] d, old, nw, exp;
    c_lvl = ty; c_dual = du; c_pol = po;
    old = pin_in;
    wr(8'h0C, ty); wr(8'h10, du); wr(8'h14, po); wr(8'h18, mk);
    repeat (5) @(negedge clk);
    wr(8'h24, 32'hFFFF_FFFF);
    exp = lvl_act(old);
    rd(8'h1C, d); check("R5 level re-set after clear", {64'b0, d}, {64'b0, exp});
    for (int k = 1; k < 14; k++) begin
      nw = (k == 1) ? ~old : (seed * k) ^ (k[0] ? 32'hFFFF_0000 : 32'h0);
      @(negedge clk); pin_in = nw;
      repeat (5) @(negedge clk);
      exp = exp | edge_hit(old, nw) | lvl_act(nw);
      rd(8'h1C, d); check("R4 R5 raw status after transition", {64'b0, d}, {64'b0, exp});
      rd(8'h20, d); check("R6 masked status", {64'b0, d}, {64'b0, exp & mk});
      check("R8 irq_out", {95'b0, irq_out}, {95'b0, |(exp & mk)});
      rd(8'h00, d); check("R3 data-in readback", {64'b0, d}, {64'b0, nw});
      wr(8'h24, 32'h0);
      rd(8'h1C, d); check("R7 zero clear no effect", {64'b0, d}, {64'b0, exp});
      wr(8'h24, 32'hFFFF_FFFF);
      exp = lvl_act(nw);
      rd(8'h1C, d); check("R7 clear leaves only active levels", {64'b0, d}, {64'b0, exp});
      rd(8'h24, d); check("R7 clear reads zero", {64'b0, d}, 96'b0);
      old = nw;
    end
  endtask

  initial begin
    logic [31:0] d, p0, p1, p2, exp;
    logic [95:0] dexp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 104; a += 4) begin
      rd(8'(a), d); check("R1 reset register zero", {64'b0, d}, 96'b0);
    end
    check("R1 reset pin_out", {64'b0, pin_out}, 96'b0);
    check("R1 reset pin_oe", {64'b0, pin_oe}, 96'b0);
    check("R1 reset pulls", {32'b0, pad_pull_up, pad_pull_dn}, 96'b0);
    check("R1 reset drive", pad_drive, 96'b0);
    check("R1 reset irq", {95'b0, irq_out}, 96'b0);

    for (int k = 0; k < 4; k++) begin
      p0 = 32'h1234_5678 * (k + 3);
      p1 = ~p0 ^ 32'h00FF_00FF;
      wr(8'h04, p0); wr(8'h08, p1);
      check("R2 pin_out", {64'b0, pin_out}, {64'b0, p0});
      check("R2 pin_oe", {64'b0, pin_oe}, {64'b0, p1});
      rd(8'h04, d); check("R2 data-out readback", {64'b0, d}, {64'b0, p0});
      rd(8'h08, d); check("R2 enable readback", {64'b0, d}, {64'b0, p1});
    end

    for (int k = 0; k < 4; k++) begin
      p0 = {8{k[1:0], 2'b01}} ^ 32'hA5A5_3C3C;
      p1 = 32'h0F0F_0F0F << k;
      wr(8'h38, p0); wr(8'h34, p1);
      check("R9 pull-up", {64'b0, pad_pull_up}, {64'b0, p0 & p1});
      check("R9 pull-down", {64'b0, pad_pull_dn}, {64'b0, p0 & ~p1});
      rd(8'h34, d); check("R9 direction readback", {64'b0, d}, {64'b0, p1});
    end

    for (int k = 0; k < 8; k++) begin
      p0 = '0; p1 = '0; p2 = '0; dexp = '0;
      for (int i = 0; i < 32; i++) begin
        logic [2:0] code;
        code = 3'((i + k) % 8);
        p0[i] = code[0]; p1[i] = code[1]; p2[i] = code[2];
        dexp[3*i +: 3] = code;
      end
      wr(8'h58, p0); wr(8'h5C, p1); wr(8'h60, p2);
      check("R10 pad_drive codes", pad_drive, dexp);
      rd(8'h5C, d); check("R10 plane 1 readback", {64'b0, d}, {64'b0, p1});
    end

    run_sweep(32'hAAAA_AAAA, 32'hCCCC_CCCC, 32'hF0F0_F0F0, 32'h0F3C_A5FF, 32'h9E37_79B1);

    @(negedge clk); pin_in = 32'h0;
    repeat (5) @(negedge clk);
    wr(8'h24, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0000_0004;
    repeat (5) @(negedge clk);
    @(negedge clk); pin_in = 32'h0000_0014;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h24; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    exp = lvl_act(32'h14) | 32'h10;
    rd(8'h1C, d); check("R7 event wins over same-cycle clear", {64'b0, d}, {64'b0, exp});

    run_sweep(32'h5555_0F0F, 32'h3333_FF00, 32'h0FF0_33CC, 32'hFFFF_FFFF, 32'h7F4A_7C15);
    run_sweep(32'h0000_0000, 32'h00FF_00FF, 32'hF00F_F00F, 32'h8000_0001, 32'h6C07_8965);

    rd(8'h1C, p0);
    rd(8'h18, p1);
    rd(8'h00, p2);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h1C, d); check("R11 raw unchanged by read-only writes", {64'b0, d}, {64'b0, p0});
    rd(8'h18, d); check("R11 mask unchanged", {64'b0, d}, {64'b0, p1});
    rd(8'h00, d); check("R11 data-in unchanged", {64'b0, d}, {64'b0, p2});
    rd(8'h40, d); check("R11 unmapped reads zero", {64'b0, d}, 96'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule